// File: doc/BRIEF.md
# Single-Wire Slave Bit Timing Engine

This block is the bit-level front end of a slave device on a single open-drain bus line. It watches a raw copy of the line and drives one output, a pulldown enable. It recognises the master's reset pulse and answers with a presence pulse. It turns master write slots into received bits and serves read slots from a transmit bit supplied by the layer above. It offers no command decoding and no storage. The upper layer sees a reset strobe, a received-bit strobe with data, and a transmit handshake in which a pending bit is taken at the start of the next slot.

Two timing sets are built in: a standard set and a faster overdrive set. The upper layer selects overdrive by pulsing a set input. A reset low that is long enough for the standard speed always drops the block back to standard speed. Every time value is a count of clock cycles derived from one clocks-per-microsecond parameter. A low pulse is classified by its length when the line returns high. Lengths in the gap between the longest write-zero and the shortest reset produce nothing.

Top module: `owb_bit_engine`

## Requirements
- R1: After reset the pulldown is off, `od_active` is 0, and no strobe is raised until the line is driven.
- R2: A one-cycle pulse on `od_set` makes `od_active` read 1 from the next cycle on, and it stays 1 through slots and short resets.
- R3: At standard speed, a master low shorter than 30 µs gives one `rx_valid` strobe with `rx_bit`=1. A low from 30 µs up to 120 µs gives one strobe with `rx_bit`=0. The strobe comes a few cycles after the line returns high.
- R4: At overdrive speed the same rule applies with a 4 µs sample point and a 16 µs write-zero limit.
- R5: A low longer than the write-zero limit of the current speed but shorter than its reset minimum raises neither `rx_valid` nor `rst_pulse`. The ranges are 120–480 µs at standard speed and 16–48 µs at overdrive.
- R6: A low of at least 480 µs at standard speed, or at least 48 µs at overdrive, raises `rst_pulse` for one cycle after the line returns high, and no `rx_valid` for that low.
- R7: A reset low of 480 µs or more clears `od_active`, and this takes priority over `od_set`. An overdrive-length reset below 480 µs leaves overdrive active.
- R8: After a reset the block pulls the line low for a presence pulse. At standard speed the pulse covers the window from 60 µs to 72 µs after the release and is off at 5 µs and at 150 µs. At overdrive it covers 8 µs to 10 µs and is off at 1 µs and at 20 µs.
- R9: When `tx_valid` is 1 at a slot's falling edge, `tx_taken` pulses once and the slot is a read slot. With `tx_bit`=0 the pulldown holds the line low past the master sample point: on at 15 µs and off by 35 µs at standard speed, on at 2 µs and off by 7 µs at overdrive. A read slot never raises `rx_valid`.
- R10: In a read slot with `tx_bit`=1 the pulldown stays off.
- R11: Edges caused by the block's own presence pulse start no slot. No `tx_taken` and no `rx_valid` occur during the presence pulse, even with `tx_valid` held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_in | input | 1 | Raw, unsynchronised level of the bus line |
| pull_en | output | 1 | Enable of the open-drain pulldown; 1 pulls the line low |
| od_set | input | 1 | One-cycle request to switch to overdrive timing |
| od_active | output | 1 | 1 while overdrive timing is in use |
| rst_pulse | output | 1 | One-cycle strobe: a bus reset was recognised |
| rx_valid | output | 1 | One-cycle strobe: a written bit was received |
| rx_bit | output | 1 | Value of the received bit, valid with `rx_valid` |
| tx_valid | input | 1 | A bit is waiting to be sent in the next slot |
| tx_bit | input | 1 | Bit to send in the next read slot |
| tx_taken | output | 1 | One-cycle strobe: the pending transmit bit was taken |

## Verification
The bench drives lows on both sides of each threshold at both speeds. A 60 µs low is a write-zero at standard speed and a reset at overdrive, so a design that mixes the two timing sets reports the wrong event. Lows in the dead band between write-zero and reset catch a design that turns every long low into a zero bit or a reset. A long reset issued in overdrive must both clear the speed flag and produce a presence pulse with standard timing. A read-zero slot whose hold is too short, or a design that treats its own presence pulse as a new slot, shows up as a wrong line level at the master sample point or as an unexpected `tx_taken`.

// File: rtl/owb_pkg.sv
package owb_pkg;

  localparam int unsigned TICK_W = 16;
  typedef logic [TICK_W-1:0] tick_t;

  // Timing set for one bus speed, all values in clock cycles
  typedef struct packed {
    tick_t sample;   // lows shorter than this are a one
    tick_t w0_max;   // longest low accepted as a zero
    tick_t rst_min;  // shortest low taken as a bus reset
    tick_t pd_wait;  // gap between reset release and presence
    tick_t pd_len;   // presence pulse length
    tick_t rd_hold;  // pulldown length for a transmitted zero
  } slot_times_t;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_LOW      = 2'd1,
    ST_PD_WAIT  = 2'd2,
    ST_PD_DRIVE = 2'd3
  } eng_state_e;

  function automatic tick_t us_to_ticks(int unsigned us, int unsigned cyc_per_us);
    return tick_t'(us * cyc_per_us);
  endfunction

  function automatic slot_times_t std_times(int unsigned cpu);
    slot_times_t t;
    t.sample  = us_to_ticks(30, cpu);
    t.w0_max  = us_to_ticks(120, cpu);
    t.rst_min = us_to_ticks(480, cpu);
    t.pd_wait = us_to_ticks(15, cpu);
    t.pd_len  = us_to_ticks(120, cpu);
    t.rd_hold = us_to_ticks(30, cpu);
    return t;
  endfunction

  function automatic slot_times_t od_times(int unsigned cpu);
    slot_times_t t;
    t.sample  = us_to_ticks(4, cpu);
    t.w0_max  = us_to_ticks(16, cpu);
    t.rst_min = us_to_ticks(48, cpu);
    t.pd_wait = us_to_ticks(2, cpu);
    t.pd_len  = us_to_ticks(12, cpu);
    t.rd_hold = us_to_ticks(4, cpu);
    return t;
  endfunction

endpackage

// File: rtl/owb_sync.sv
module owb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic fall,
  output logic rise
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], line_in};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign line_s = sh_q[STAGES-1];
  assign fall   = prev_q & ~line_s;
  assign rise   = ~prev_q & line_s;

endmodule

// File: rtl/owb_tick_counter.sv
module owb_tick_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (en && (cnt_q != '1))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/owb_len_class.sv
module owb_len_class
  import owb_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 4
) (
  input  tick_t       len,
  input  slot_times_t tm,
  output logic        is_one,
  output logic        is_zero,
  output logic        is_rst,
  output logic        is_long
);

  localparam tick_t LONG_MIN = us_to_ticks(480, CYC_PER_US);

  always_comb begin
    is_long = (len >= LONG_MIN);
    is_rst  = (len >= tm.rst_min) || is_long;
    is_one  = !is_rst && (len < tm.sample);
    is_zero = !is_rst && (len >= tm.sample) && (len <= tm.w0_max);
  end

endmodule

// File: rtl/owb_bit_engine.sv
module owb_bit_engine
  import owb_pkg::*;
#(
  parameter int unsigned CYC_PER_US  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic bus_in,
  output logic pull_en,
  input  logic od_set,
  output logic od_active,
  output logic rst_pulse,
  output logic rx_valid,
  output logic rx_bit,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic tx_taken
);

  localparam slot_times_t T_STD = std_times(CYC_PER_US);
  localparam slot_times_t T_OD  = od_times(CYC_PER_US);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic line_s, fall, rise;
  owb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(bus_in),
    .line_s(line_s), .fall(fall), .rise(rise)
  );

  logic  cnt_clr, cnt_en;
  tick_t cnt;
  owb_tick_counter #(.W(TICK_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en), .cnt(cnt)
  );

  logic        od_q, od_d;
  slot_times_t tm;
  assign tm = od_q ? T_OD : T_STD;

  logic is_one, is_zero, is_rst, is_long;
  owb_len_class #(.CYC_PER_US(CYC_PER_US)) u_class (
    .len(cnt), .tm(tm),
    .is_one(is_one), .is_zero(is_zero), .is_rst(is_rst), .is_long(is_long)
  );

  eng_state_e state_q, state_d;
  logic rd_q, rd_d, rd0_q, rd0_d;
  logic rxv_q, rxv_d, rxb_q, rxb_d, rst_q, rst_d, take_q, take_d;

  always_comb begin
    state_d = state_q;
    rd_d    = rd_q;
    rd0_d   = rd0_q;
    rxb_d   = rxb_q;
    rxv_d   = 1'b0;
    rst_d   = 1'b0;
    take_d  = 1'b0;
    cnt_clr = 1'b0;
    cnt_en  = 1'b1;
    od_d    = od_q | od_set;
    unique case (state_q)
      ST_IDLE: begin
        if (fall) begin
          state_d = ST_LOW;
          cnt_clr = 1'b1;
          rd_d    = tx_valid;
          rd0_d   = tx_valid & ~tx_bit;
          take_d  = tx_valid;
        end
      end
      ST_LOW: begin
        if (rise) begin
          state_d = ST_IDLE;
          if (is_rst) begin
            state_d = ST_PD_WAIT;
            cnt_clr = 1'b1;
            rst_d   = 1'b1;
            if (is_long) od_d = 1'b0;
          end else if (!rd_q && (is_one || is_zero)) begin
            rxv_d = 1'b1;
            rxb_d = is_one;
          end
        end
      end
      ST_PD_WAIT: begin
        if (cnt >= tm.pd_wait) begin
          state_d = ST_PD_DRIVE;
          cnt_clr = 1'b1;
        end
      end
      ST_PD_DRIVE: begin
        if (cnt >= tm.pd_len) begin
          state_d = ST_IDLE;
          cnt_clr = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
      rd0_q   <= 1'b0;
      od_q    <= 1'b0;
      rxv_q   <= 1'b0;
      rxb_q   <= 1'b0;
      rst_q   <= 1'b0;
      take_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
      rd0_q   <= rd0_d;
      od_q    <= od_d;
      rxv_q   <= rxv_d;
      rxb_q   <= rxb_d;
      rst_q   <= rst_d;
      take_q  <= take_d;
    end
  end

  assign pull_en   = (state_q == ST_PD_DRIVE) ||
                     ((state_q == ST_LOW) && rd0_q && (cnt < tm.rd_hold));
  assign od_active = od_q;
  assign rst_pulse = rst_q;
  assign rx_valid  = rxv_q;
  assign rx_bit    = rxb_q;
  assign tx_taken  = take_q;

  // length of the current pulldown run, for the bound check
  tick_t pull_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pull_run_q <= '0;
    else if (!pull_en)                  pull_run_q <= '0;
    else if (pull_run_q != '1)          pull_run_q <= pull_run_q + 1'b1;
  end

  p_rx_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rise));

  p_no_bit_with_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> !rx_valid);

  p_od_drop_on_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(od_active) |-> rst_pulse);

  p_pull_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pull_en |-> (pull_run_q <= T_STD.pd_len));

  p_take_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken |-> $past(fall));

  p_one_never_pulls_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOW && rd_q && !rd0_q) |-> !pull_en);

  p_quiet_presence_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PD_WAIT || state_q == ST_PD_DRIVE) |-> (!rx_valid && !tx_taken));

endmodule

// File: tb/tb_owb_bit_engine.sv
module tb_owb_bit_engine;

  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic m_low = 1'b0;
  logic od_set = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_bit = 1'b1;
  logic pull_en, od_active, rst_pulse, rx_valid, rx_bit, tx_taken;
  logic bus_line;

  assign bus_line = ~(m_low | pull_en);

  always #(CLK_PERIOD/2) clk = ~clk;

  owb_bit_engine #(.CYC_PER_US(CPU), .SYNC_STAGES(2)) dut (
    .clk(clk), .arst_n(arst_n), .bus_in(bus_line), .pull_en(pull_en),
    .od_set(od_set), .od_active(od_active), .rst_pulse(rst_pulse),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_valid(tx_valid),
    .tx_bit(tx_bit), .tx_taken(tx_taken)
  );

  int n_chk = 0, n_bad = 0;
  int rx_cnt = 0, rx_last = -1, rst_cnt = 0, take_cnt = 0;

  always @(negedge clk) begin
    if (rx_valid)  begin rx_cnt++; rx_last = int'(rx_bit); end
    if (rst_pulse) rst_cnt++;
    if (tx_taken)  take_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic master_low(input int cyc);
    m_low = 1'b1;
    repeat (cyc) @(negedge clk);
    m_low = 1'b0;
  endtask

  // write slot of a given low length, then check the received event
  task automatic write_slot(input string req, input int cyc, input int exp_rx, input int exp_bit);
    int rx0 = rx_cnt, rs0 = rst_cnt;
    master_low(cyc);
    idle(12);
    chk({req, " rx count"}, rx_cnt - rx0, exp_rx);
    chk({req, " no reset"}, rst_cnt - rs0, 0);
    if (exp_rx != 0) chk({req, " rx bit"}, rx_last, exp_bit);
  endtask

  // reset low then presence window checks (R8)
  task automatic reset_and_presence(input string req, input int cyc, input bit od_timing);
    int rs0 = rst_cnt, tk0 = take_cnt, rx0 = rx_cnt;
    int t_off1 = od_timing ? 1*CPU : 5*CPU;
    int t_on   = od_timing ? 9*CPU : 66*CPU;
    int t_off2 = od_timing ? 20*CPU : 150*CPU;
    master_low(cyc);
    tx_valid = 1'b1; tx_bit = 1'b0;
    for (int i = 1; i <= t_off2; i++) begin
      @(negedge clk);
      if (i == t_off1) chk({req, " R8 presence not yet"}, int'(pull_en), 0);
      if (i == t_on)   chk({req, " R8 presence active"}, int'(pull_en), 1);
    end
    chk({req, " R8 presence ended"}, int'(pull_en), 0);
    tx_valid = 1'b0; tx_bit = 1'b1;
    chk({req, " R6 reset strobe"}, rst_cnt - rs0, 1);
    chk({req, " R11 no take in presence"}, take_cnt - tk0, 0);
    chk({req, " R11 no rx in presence"}, rx_cnt - rx0, 0);
    idle(10);
  endtask

  // read slot: master low 1 us, check line level at two points
  task automatic read_slot(input string req, input bit b, input int t_on, input int t_off);
    int tk0 = take_cnt, rx0 = rx_cnt;
    tx_valid = 1'b1; tx_bit = b;
    @(negedge clk);
    m_low = 1'b1;
    for (int i = 1; i <= t_off; i++) begin
      @(negedge clk);
      if (i == CPU) m_low = 1'b0;
      if (i == t_on) chk({req, " level at sample"}, int'(pull_en), b ? 0 : 1);
    end
    chk({req, " released"}, int'(pull_en), 0);
    tx_valid = 1'b0; tx_bit = 1'b1;
    idle(20);
    chk({req, " R9 taken once"}, take_cnt - tk0, 1);
    chk({req, " R9 no rx"}, rx_cnt - rx0, 0);
  endtask

  task automatic t_reset_state();
    chk("R1 pull off", int'(pull_en), 0);
    chk("R1 od off", int'(od_active), 0);
    chk("R1 no strobes", rx_cnt + rst_cnt + take_cnt, 0);
  endtask

  task automatic t_std_reset();
    reset_and_presence("R6 std reset", 500*CPU, 1'b0);
    chk("R7 std stays std", int'(od_active), 0);
  endtask

  task automatic t_std_writes();
    write_slot("R3 std one", 6*CPU, 1, 1);
    write_slot("R3 std zero", 70*CPU, 1, 0);
    write_slot("R3 std 60us zero", 60*CPU, 1, 0);
  endtask

  task automatic t_std_gap();
    write_slot("R5 std 200us", 200*CPU, 0, 0);
    write_slot("R5 std 400us", 400*CPU, 0, 0);
  endtask

  task automatic t_std_reads();
    read_slot("R9 std zero", 1'b0, 15*CPU, 35*CPU);
    read_slot("R10 std one", 1'b1, 15*CPU, 35*CPU);
  endtask

  task automatic t_set_od();
    od_set = 1'b1; @(negedge clk); od_set = 1'b0;
    chk("R2 od set", int'(od_active), 1);
    idle(5);
  endtask

  task automatic t_od_writes();
    write_slot("R4 od one", 1*CPU, 1, 1);
    write_slot("R4 od zero", 10*CPU, 1, 0);
    write_slot("R5 od 30us", 30*CPU, 0, 0);
    chk("R2 od holds", int'(od_active), 1);
  endtask

  task automatic t_od_reset();
    reset_and_presence("R6 od reset", 60*CPU, 1'b1);
    chk("R7 short reset keeps od", int'(od_active), 1);
  endtask

  task automatic t_od_reads();
    read_slot("R9 od zero", 1'b0, 2*CPU, 7*CPU);
    read_slot("R10 od one", 1'b1, 2*CPU, 7*CPU);
  endtask

  task automatic t_long_reset_in_od();
    reset_and_presence("R7 long reset", 500*CPU, 1'b0);
    chk("R7 long reset clears od", int'(od_active), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    arst_n = 1'b1;
    idle(5);
    t_reset_state();
    t_std_reset();
    t_std_writes();
    t_std_gap();
    t_std_reads();
    t_set_od();
    t_od_writes();
    t_od_reset();
    t_od_reads();
    t_long_reset_in_od();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule